// File: doc/BRIEF.md
# Dual-Port Audio Interrupt and Reset Controller

This block is the shared control point for two audio ports, A and B. Each port has an output (playback) direction and an input (capture) direction, and each direction raises its own FIFO service request. The controller records those four requests in a sticky status register. It gates them through two mask registers and drives one registered interrupt line to the processor.

It also holds a software reset register and a per-port clock-enable register, and drives the port reset and clock-enable lines from them. The reset register does two more jobs. Bit 0 releases the global soft reset. A low-then-high sequence on bit 4 acknowledges the pending interrupt.

Software reaches every register through a simple single-cycle write/read bus. Reads are combinational on the address.

Top module: `audio_irq_ctrl`

## Requirements
- R1: A rising edge on a request input sets its status bit on the next clock. The status bits sit at bit 0 (port A output, `fifo_req[0]`), bit 4 (port A input, `fifo_req[1]`), bit 8 (port B output, `fifo_req[2]`) and bit 12 (port B input, `fifo_req[3]`) of the status register at byte offset 0x00. All other bits read zero.
- R2: A set status bit stays set after its request drops. A request held high sets its bit only once, so a cleared bit does not come back while the request stays high.
- R3: A write to the status register clears each status bit whose data bit is 0 and leaves alone each bit whose data bit is 1. If a rising request and a clearing write land in the same cycle, the bit ends up set.
- R4: There are two mask registers, at offsets 0x04 and 0x08, with the same bit layout as the status register. Only bits 0, 4, 8 and 12 are stored; the rest read zero. `irq` goes high one clock after some status bit is set in both masks. It does not go high if a bit is set in only one of them.
- R5: The reset register sits at offset 0x10. While its bit 0 is 0 (global soft reset asserted), `irq` is low on the following clock and stays low, whatever is pending.
- R6: While bit 4 of the reset register is 0, `irq` is held low. A write that takes bit 4 from 0 to 1 acknowledges the pending interrupt: `irq` stays low until a new request rising edge sets a status bit.
- R7: The reset register keeps only data bits 7:0, and bits 31:8 read zero. `port_rst_n[0]` is high only when bits 0 and 5 are both 1. `port_rst_n[1]` is high only when bits 0 and 6 are both 1.
- R8: The clock register sits at offset 0x0C. Bit 0 drives `port_clk_en[0]` (port A) and bit 4 drives `port_clk_en[1]` (port B). No other bits are stored.
- R9: A read from any offset other than 0x00, 0x04, 0x08, 0x0C or 0x10 returns zero. A write to such an offset changes no register.
- R10: After `rst_n` is held low for a clock, every register reads zero, `irq` is low, both port resets are asserted (low) and both clock enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| fifo_req | input | 4 | Service requests: A out, A in, B out, B in |
| irq | output | 1 | Registered interrupt line |
| port_rst_n | output | 2 | Active-low reset to port A (bit 0) and port B (bit 1) |
| port_clk_en | output | 2 | Clock enable to port A (bit 0) and port B (bit 1) |

## Verification
The bench focuses on three kinds of corner case.

- **Edge handling.** It holds a request high across a clear, and it lands a rising request in the same cycle as a clearing write. A design that latched levels instead of edges would re-raise the cleared bit. A design that gave the write priority would lose the request.
- **Mask gating.** It sets a source in only one mask and confirms the line stays quiet. A design that ORed the masks would raise `irq` there.
- **Reset-register sequencing.** It parks a pending interrupt, drops and raises bit 4, and checks that `irq` stays low until a fresh event. A design that only gated on the level of bit 4 would re-fire at once. A design that never cleared the acknowledge would never fire again.

// File: rtl/audctl_pkg.sv
// Shared constants for the dual-port audio interrupt and reset controller.
// Assumes four request sources laid out one per nibble and two ports.
package audctl_pkg;
    localparam int NUM_SRC    = 4;
    localparam int SRC_STRIDE = 4;
    localparam int NUM_PORTS  = 2;

    localparam int OFF_STATUS    = 'h00;
    localparam int OFF_MASK_SRC  = 'h04;
    localparam int OFF_MASK_LINE = 'h08;
    localparam int OFF_CLKCTL    = 'h0C;
    localparam int OFF_SRST      = 'h10;

    localparam int SRST_KEEP_W = 8;
    localparam int SR_GLOBAL   = 0;
    localparam int SR_ACK      = 4;
    localparam int SR_PORT0    = 5;
    localparam int CK_STRIDE   = 4;
endpackage

// File: rtl/audctl_status.sv
// Sticky request status: edge-detects each request and holds it until software
// clears it with a zero bit. Assumes requests are synchronous to clk.
module audctl_status #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            wr_i,
    input  logic [NSRC-1:0] keep_i,
    output logic [NSRC-1:0] status_o,
    output logic            new_evt_o
);
    logic [NSRC-1:0] req_q;
    logic [NSRC-1:0] rise;

    assign rise      = req_i & ~req_q;
    assign new_evt_o = |rise;

    // Remember last request level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_i;
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        // Set on rising request, clear on a zero write bit; set wins.
        always_ff @(posedge clk) begin
            if (!rst_n)                  status_o[k] <= 1'b0;
            else if (rise[k])            status_o[k] <= 1'b1;
            else if (wr_i && !keep_i[k]) status_o[k] <= 1'b0;
        end

        p_rise_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i[k] && !req_q[k]) |=> status_o[k]);
        p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (status_o[k] && !wr_i) |=> status_o[k]);
    end
endmodule

// File: rtl/audctl_irq.sv
// Interrupt line: ANDs status with both masks, applies global-reset and
// acknowledge gating, and registers the result. Assumes one-cycle ack pulse.
module audctl_irq #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] status_i,
    input  logic [NSRC-1:0] mask_src_i,
    input  logic [NSRC-1:0] mask_line_i,
    input  logic            glob_rel_i,
    input  logic            ack_lvl_i,
    input  logic            ack_pulse_i,
    input  logic            new_evt_i,
    output logic            irq_o
);
    logic pend;
    logic ack_q;

    assign pend = |(status_i & mask_src_i & mask_line_i);

    // Acknowledge holds off the line until a fresh request edge.
    always_ff @(posedge clk) begin
        if (!rst_n)           ack_q <= 1'b0;
        else if (new_evt_i)   ack_q <= 1'b0;
        else if (ack_pulse_i) ack_q <= 1'b1;
    end

    // Registered interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= pend && glob_rel_i && ack_lvl_i && !ack_q;
    end

    p_irq_needs_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(status_i & mask_src_i & mask_line_i)));
    p_irq_off_in_srst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_rel_i |=> !irq_o);
    p_ack_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q || !ack_lvl_i) |=> !irq_o);
endmodule

// File: rtl/audctl_regs.sv
// Register bank: address decode, mask, clock and soft-reset storage and the
// read mux. Assumes byte offsets and one access per cycle.
module audctl_regs
    import audctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NSRC   = 4,
    parameter int NPORT  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic [NSRC-1:0]        status_i,
    output logic                   st_wr_o,
    output logic [NSRC-1:0]        st_keep_o,
    output logic [NSRC-1:0]        mask_src_o,
    output logic [NSRC-1:0]        mask_line_o,
    output logic [NPORT-1:0]       clk_ctl_o,
    output logic [SRST_KEEP_W-1:0] srst_o,
    output logic                   ack_pulse_o,
    output logic [DATA_W-1:0]      rdata_o
);
    logic hit_st, hit_ms, hit_ml, hit_ck, hit_sr, hit_any;
    logic [NSRC-1:0]  wd_src;
    logic [NPORT-1:0] wd_clk;
    logic unused_wdata;

    assign hit_st  = addr_i == ADDR_W'(OFF_STATUS);
    assign hit_ms  = addr_i == ADDR_W'(OFF_MASK_SRC);
    assign hit_ml  = addr_i == ADDR_W'(OFF_MASK_LINE);
    assign hit_ck  = addr_i == ADDR_W'(OFF_CLKCTL);
    assign hit_sr  = addr_i == ADDR_W'(OFF_SRST);
    assign hit_any = hit_st | hit_ms | hit_ml | hit_ck | hit_sr;
    assign unused_wdata = ^wdata_i;

    for (genvar k = 0; k < NSRC; k++) begin : g_wsrc
        assign wd_src[k] = wdata_i[k*SRC_STRIDE];
    end
    for (genvar p = 0; p < NPORT; p++) begin : g_wclk
        assign wd_clk[p] = wdata_i[p*CK_STRIDE];
    end

    assign st_wr_o     = we_i && hit_st;
    assign st_keep_o   = wd_src;
    assign ack_pulse_o = we_i && hit_sr && wdata_i[SR_ACK] && !srst_o[SR_ACK];

    // Mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_src_o  <= '0;
            mask_line_o <= '0;
        end else if (we_i) begin
            if (hit_ms) mask_src_o  <= wd_src;
            if (hit_ml) mask_line_o <= wd_src;
        end
    end

    // Clock-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)              clk_ctl_o <= '0;
        else if (we_i && hit_ck) clk_ctl_o <= wd_clk;
    end

    // Soft-reset register, low byte only.
    always_ff @(posedge clk) begin
        if (!rst_n)              srst_o <= '0;
        else if (we_i && hit_sr) srst_o <= wdata_i[SRST_KEEP_W-1:0];
    end

    // Read multiplexer; unmapped offsets read zero.
    always_comb begin
        rdata_o = '0;
        if (hit_st) begin
            for (int k = 0; k < NSRC; k++) rdata_o[k*SRC_STRIDE] = status_i[k];
        end else if (hit_ms) begin
            for (int k = 0; k < NSRC; k++) rdata_o[k*SRC_STRIDE] = mask_src_o[k];
        end else if (hit_ml) begin
            for (int k = 0; k < NSRC; k++) rdata_o[k*SRC_STRIDE] = mask_line_o[k];
        end else if (hit_ck) begin
            for (int p = 0; p < NPORT; p++) rdata_o[p*CK_STRIDE] = clk_ctl_o[p];
        end else if (hit_sr) begin
            rdata_o[SRST_KEEP_W-1:0] = srst_o;
        end
    end

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_any |-> (rdata_o == '0));
    p_srst_high_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_sr |-> (rdata_o[DATA_W-1:SRST_KEEP_W] == '0));
    p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !hit_any) |=> ($stable(srst_o) && $stable(clk_ctl_o)
                                && $stable(mask_src_o) && $stable(mask_line_o)));
endmodule

// File: rtl/audio_irq_ctrl.sv
// Top of the dual-port audio interrupt and reset controller. Wires status,
// register bank and interrupt generator; derives port reset and clock lines.
module audio_irq_ctrl
    import audctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_SRC-1:0]   fifo_req,
    output logic                 irq,
    output logic [NUM_PORTS-1:0] port_rst_n,
    output logic [NUM_PORTS-1:0] port_clk_en
);
    logic [NUM_SRC-1:0]     status, keep, mask_src, mask_line;
    logic                   st_wr, new_evt, ack_pulse;
    logic [NUM_PORTS-1:0]   clk_ctl;
    logic [SRST_KEEP_W-1:0] srst;

    audctl_status #(.NSRC(NUM_SRC)) u_status (
        .clk(clk), .rst_n(rst_n), .req_i(fifo_req), .wr_i(st_wr),
        .keep_i(keep), .status_o(status), .new_evt_o(new_evt)
    );

    audctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NUM_SRC),
                  .NPORT(NUM_PORTS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .status_i(status), .st_wr_o(st_wr),
        .st_keep_o(keep), .mask_src_o(mask_src), .mask_line_o(mask_line),
        .clk_ctl_o(clk_ctl), .srst_o(srst), .ack_pulse_o(ack_pulse),
        .rdata_o(bus_rdata)
    );

    audctl_irq #(.NSRC(NUM_SRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .status_i(status), .mask_src_i(mask_src),
        .mask_line_i(mask_line), .glob_rel_i(srst[SR_GLOBAL]),
        .ack_lvl_i(srst[SR_ACK]), .ack_pulse_i(ack_pulse),
        .new_evt_i(new_evt), .irq_o(irq)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign port_rst_n[p]  = srst[SR_GLOBAL] & srst[SR_PORT0+p];
        assign port_clk_en[p] = clk_ctl[p];
    end

    p_port_rst_global_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !srst[SR_GLOBAL] |-> (port_rst_n == '0));
endmodule

// File: tb/audio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module audio_irq_ctrl_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_we = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [3:0]  fifo_req = 0;
    logic        irq;
    logic [1:0]  port_rst_n, port_clk_en;

    int checks = 0, fails = 0;
    bit done = 0, started = 0;

    always #2 clk = ~clk;

    audio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_req(fifo_req),
        .irq(irq), .port_rst_n(port_rst_n), .port_clk_en(port_clk_en)
    );

    // Behavioural reference model, advanced on each rising edge.
    bit [3:0] m_st, m_ms, m_ml, m_reqp;
    bit [1:0] m_ck;
    bit [7:0] m_sr;
    bit       m_ack, m_irq;

    always @(posedge clk) begin
        bit [3:0] rise;
        bit nirq;
        started = 1;
        if (!rst_n) begin
            m_st = 0; m_ms = 0; m_ml = 0; m_reqp = 0; m_ck = 0; m_sr = 0;
            m_ack = 0; m_irq = 0;
        end else begin
            rise = fifo_req & ~m_reqp;
            nirq = (|(m_st & m_ms & m_ml)) && m_sr[0] && m_sr[4] && !m_ack;
            if (|rise) m_ack = 0;
            else if (bus_we && bus_addr == 8'h10 && bus_wdata[4] && !m_sr[4]) m_ack = 1;
            if (bus_we) begin
                case (bus_addr)
                    8'h00: for (int k = 0; k < 4; k++) if (!bus_wdata[4*k]) m_st[k] = 0;
                    8'h04: for (int k = 0; k < 4; k++) m_ms[k] = bus_wdata[4*k];
                    8'h08: for (int k = 0; k < 4; k++) m_ml[k] = bus_wdata[4*k];
                    8'h0C: m_ck = {bus_wdata[4], bus_wdata[0]};
                    8'h10: m_sr = bus_wdata[7:0];
                    default: ;
                endcase
            end
            m_st = m_st | rise;
            m_reqp = fifo_req;
            m_irq = nirq;
        end
    end

    // Per-cycle comparison of the outputs against the model (R4 R5 R6 R7 R8).
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (irq !== m_irq || port_rst_n !== {m_sr[0] & m_sr[6], m_sr[0] & m_sr[5]}
                || port_clk_en !== m_ck) begin
                fails++;
                $display("FAIL R4 R5 R6 R7 R8 model t=%0t irq=%b/%b rst=%b/%b clk=%b/%b",
                         $time, irq, m_irq, port_rst_n,
                         {m_sr[0] & m_sr[6], m_sr[0] & m_sr[5]}, port_clk_en, m_ck);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pulse(input int k);
        @(negedge clk); fifo_req[k] = 1;
        @(negedge clk); fifo_req[k] = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(4);
        // R10 reset state
        rd("R10 status", 8'h00, 0); rd("R10 mask_src", 8'h04, 0);
        rd("R10 mask_line", 8'h08, 0); rd("R10 clk", 8'h0C, 0);
        rd("R10 srst", 8'h10, 0);
        chk("R10 outputs", {29'd0, irq, port_rst_n} , 0);
        chk("R10 clk_en", {30'd0, port_clk_en}, 0);
        rst_n = 1;
        idle(1);

        // R7 reset register width and port releases
        wr(8'h10, 32'h0000_01FF); rd("R7 keep low byte", 8'h10, 32'hFF);
        chk("R7 both released", {30'd0, port_rst_n}, 2'b11);
        wr(8'h10, 32'h21); chk("R7 only port A", {30'd0, port_rst_n}, 2'b01);
        wr(8'h10, 32'h60); chk("R7 global holds both", {30'd0, port_rst_n}, 2'b00);
        wr(8'h10, 32'h71);

        // R8 clock enables
        wr(8'h0C, 32'hFFFF_FFFF); rd("R8 clk read", 8'h0C, 32'h11);
        chk("R8 both on", {30'd0, port_clk_en}, 2'b11);
        wr(8'h0C, 32'h10); chk("R8 only B", {30'd0, port_clk_en}, 2'b10);

        // R1 bit positions, R2 sticky after request drops
        pulse(0); idle(1); rd("R1 A out bit0", 8'h00, 32'h0001);
        pulse(1); idle(1); rd("R1 A in bit4", 8'h00, 32'h0011);
        pulse(2); idle(1); rd("R1 B out bit8", 8'h00, 32'h0111);
        pulse(3); idle(1); rd("R2 B in bit12 sticky", 8'h00, 32'h1111);

        // R3 zero clears, one keeps
        wr(8'h00, 32'hFFFF_FFFE); rd("R3 partial clear", 8'h00, 32'h1110);
        wr(8'h00, 32'h0); rd("R3 full clear", 8'h00, 32'h0);

        // R2 held request does not re-set after clear
        @(negedge clk); fifo_req[0] = 1;
        idle(2); rd("R2 held sets once", 8'h00, 32'h1);
        wr(8'h00, 32'h0); idle(2); rd("R2 held no reset", 8'h00, 32'h0);
        fifo_req[0] = 0; idle(1);

        // R4 dual masks
        wr(8'h04, 32'hFFFF_FFFF); rd("R4 mask_src layout", 8'h04, 32'h1111);
        wr(8'h08, 32'h0000_0001); rd("R4 mask_line", 8'h08, 32'h1);
        pulse(2); idle(2); chk("R4 one mask only", {31'd0, irq}, 0);
        pulse(0); idle(1); chk("R4 both masks irq", {31'd0, irq}, 1);

        // R5 global soft reset silences irq
        wr(8'h10, 32'h70); idle(1); chk("R5 irq low in srst", {31'd0, irq}, 0);
        wr(8'h10, 32'h71); idle(1); chk("R5 irq back", {31'd0, irq}, 1);

        // R6 acknowledge sequence
        wr(8'h10, 32'h61); idle(1); chk("R6 bit4 low", {31'd0, irq}, 0);
        wr(8'h10, 32'h71); idle(3); chk("R6 acked stays low", {31'd0, irq}, 0);
        rd("R6 still pending", 8'h00, 32'h0101);
        wr(8'h08, 32'h1001);
        pulse(3); idle(1); chk("R6 new event fires", {31'd0, irq}, 1);

        // R9 unmapped offsets
        wr(8'h14, 32'hFFFF_FFFF); wr(8'h40, 32'hFFFF_FFFF); wr(8'hFC, 32'h0);
        rd("R9 read 0x14", 8'h14, 0); rd("R9 read 0x40", 8'h40, 0);
        rd("R9 read 0xFC", 8'hFC, 0);
        rd("R9 status kept", 8'h00, 32'h1101); rd("R9 mask_src kept", 8'h04, 32'h1111);
        rd("R9 mask_line kept", 8'h08, 32'h1001); rd("R9 clk kept", 8'h0C, 32'h10);
        rd("R9 srst kept", 8'h10, 32'h71);

        // R3 set wins over a same-cycle clear
        @(negedge clk);
        fifo_req[1] = 1; bus_we = 1; bus_addr = 8'h00; bus_wdata = 32'h0;
        @(negedge clk);
        bus_we = 0; fifo_req[1] = 0;
        rd("R3 set wins", 8'h00, 32'h0010);
        idle(1); chk("R3 R4 irq after clear", {31'd0, irq}, 0);

        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule